// File: doc/BRIEF.md
# Double-Precision Ordered Compare Unit

This unit executes one ordered compare of two 64-bit IEEE-754 double-precision values per accepted strobe. It sorts each operand into a class: zero, quiet NaN, signaling NaN or ordinary value. It then finds where operand A stands relative to operand B and forms a four-bit code. The code marks A as below B, above B, equal to B, or the pair as unordered.

The code goes into two places. It overwrites the code field of a 32-bit floating-point status word. It is also steered into one of eight 4-bit fields of a 32-bit condition word, selected by a 3-bit field index. The other seven fields keep their values. The same commit sets two sticky invalid-operation flags when NaN operands appear. The ordered-compare rule applies: a quiet NaN counts as an invalid compare, and so does a signaling NaN when invalid-operation trapping is disabled.

A two-state controller governs the commit. ST_IDLE goes to ST_COMMIT when `valid_i` is high. ST_COMMIT stays in ST_COMMIT on a back-to-back strobe and returns to ST_IDLE otherwise. `done_o` is high exactly while the controller is in ST_COMMIT.

Top module: `dp_ordcmp_unit`

## Requirements
- R1: After reset, `cr_o` and `fpscr_o` are zero and `done_o` is low.
- R2: A strobe on `valid_i` sampled at a clock edge updates `cr_o` and `fpscr_o` at that edge. `done_o` is high for the following cycle. `done_o` is never high without a strobe at the previous edge.
- R3: For ordered operands, the code bits in `fpscr_o` are: bit 15 set when A < B, bit 14 set when A > B, bit 13 set when A == B. Exactly one of bits 15..12 is set after each commit.
- R4: +0 and -0 compare equal in either order. Infinities compare by sign, like finite values.
- R5: If either operand is a NaN (exponent all ones, fraction nonzero), only the unordered bit is set: `fpscr_o` bit 12, and the lowest bit of the code nibble.
- R6: If either operand is a signaling NaN (a NaN with fraction MSB 0), `fpscr_o` bit 24 is set.
- R7: A signaling NaN with `inv_en_i`=0 also sets `fpscr_o` bit 19. With `inv_en_i`=1, a signaling NaN alone leaves bit 19 unchanged.
- R8: If either operand is a quiet NaN (fraction MSB 1), `fpscr_o` bit 19 is set, whatever the value of `inv_en_i`.
- R9: The code nibble, ordered {lt, gt, eq, un} from MSB to LSB, is written to `cr_o[31-4n -: 4]` with n = `bf_i`. All other bits of `cr_o` are unchanged.
- R10: Every commit overwrites all four code bits of `fpscr_o`, so no bit of the previous code remains.
- R11: Bits 24 and 19 of `fpscr_o` are sticky. Only reset clears them.
- R12: Without a strobe, `cr_o` and `fpscr_o` hold their values whatever the operands, field index or enable do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Compare request strobe |
| opa_i | input | 64 | Operand A (double precision) |
| opb_i | input | 64 | Operand B (double precision) |
| bf_i | input | 3 | Destination condition field index |
| inv_en_i | input | 1 | Invalid-operation trap enable |
| cr_o | output | 32 | Condition register |
| fpscr_o | output | 32 | Floating-point status register |
| done_o | output | 1 | Commit pulse, one cycle after the strobe |

## Verification
The bench compares signed zeros in both orders. A design that compares raw bits would report them unequal. It orders negative values and infinities against each other. A comparator that ignores the sign-magnitude encoding would invert those results.

The bench also separates the two NaN flavours, with trapping both enabled and disabled, starting from a fresh reset each time. A design that raised the invalid-compare flag for every NaN, or missed it for a quiet NaN, shows up at once. Other checks cover writes to the first and last condition fields, a later ordered compare after NaN flags are raised, and operand changes while no strobe is present. These catch a wrong field offset, clobbered neighbouring fields, a stale code bit, lost sticky flags, and registers that follow the inputs.

// File: rtl/dpcmp_pkg.sv
package dpcmp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } cmp_state_e;

    typedef struct packed {
        logic is_zero;
        logic is_nan;
        logic is_qnan;
        logic is_snan;
    } opclass_t;

    // Status word bit positions (LSB-0)
    localparam int SW_LT_BIT     = 15;
    localparam int SW_GT_BIT     = 14;
    localparam int SW_EQ_BIT     = 13;
    localparam int SW_UN_BIT     = 12;
    localparam int SW_INVCMP_BIT = 19;
    localparam int SW_SIGNAN_BIT = 24;
    localparam int SW_W          = 32;

    localparam logic [3:0] CODE_UNORD = 4'b0001;

endpackage

// File: rtl/dpcmp_classify.sv
module dpcmp_classify
    import dpcmp_pkg::*;
#(
    parameter int DW    = 64,
    parameter int EXP_W = 11
) (
    input  logic [DW-1:0] op_i,
    output opclass_t      cls_o
);
    localparam int FRAC_W = DW - 1 - EXP_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              frac_nz;

    always_comb begin
        exp_f          = op_i[DW-2 -: EXP_W];
        frac_f         = op_i[FRAC_W-1:0];
        exp_max        = &exp_f;
        frac_nz        = |frac_f;
        cls_o.is_zero  = (exp_f == '0) && !frac_nz;
        cls_o.is_nan   = exp_max && frac_nz;
        cls_o.is_qnan  = exp_max && frac_f[FRAC_W-1];
        cls_o.is_snan  = exp_max && frac_nz && !frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/dpcmp_order.sv
module dpcmp_order #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          a_zero_i,
    input  logic          b_zero_i,
    output logic          lt_o,
    output logic          gt_o,
    output logic          eq_o
);
    // Map sign-magnitude onto an unsigned monotonic key
    function automatic logic [DW-1:0] order_key(input logic [DW-1:0] v);
        if (v[DW-1]) order_key = ~v;
        else         order_key = {1'b1, v[DW-2:0]};
    endfunction

    logic [DW-1:0] key_a;
    logic [DW-1:0] key_b;

    always_comb begin
        key_a = order_key(a_i);
        key_b = order_key(b_i);
        eq_o  = (a_zero_i && b_zero_i) || (a_i == b_i);
        lt_o  = !eq_o && (key_a < key_b);
        gt_o  = !eq_o && (key_a > key_b);
    end
endmodule

// File: rtl/dpcmp_fieldwrite.sv
module dpcmp_fieldwrite #(
    parameter int NFIELD = 8,
    parameter int FW     = 4
) (
    input  logic [NFIELD*FW-1:0]       cr_i,
    input  logic [$clog2(NFIELD)-1:0]  idx_i,
    input  logic [FW-1:0]              code_i,
    output logic [NFIELD*FW-1:0]       cr_o
);
    localparam int IDX_W = $clog2(NFIELD);

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        // Field 0 sits at the most significant end
        localparam int LO = (NFIELD - 1 - g) * FW;
        assign cr_o[LO +: FW] = (idx_i == IDX_W'(g)) ? code_i : cr_i[LO +: FW];
    end
endmodule

// File: rtl/dp_ordcmp_unit.sv
module dp_ordcmp_unit
    import dpcmp_pkg::*;
#(
    parameter int DW     = 64,
    parameter int EXP_W  = 11,
    parameter int NFIELD = 8,
    parameter int FW     = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       valid_i,
    input  logic [DW-1:0]              opa_i,
    input  logic [DW-1:0]              opb_i,
    input  logic [$clog2(NFIELD)-1:0]  bf_i,
    input  logic                       inv_en_i,
    output logic [NFIELD*FW-1:0]       cr_o,
    output logic [SW_W-1:0]            fpscr_o,
    output logic                       done_o
);
    localparam int CR_W = NFIELD * FW;

    cmp_state_e state_q, state_d;

    opclass_t         cls_a, cls_b;
    logic             lt, gt, eq;
    logic             unord, snan_any, qnan_any;
    logic [FW-1:0]    code;
    logic [CR_W-1:0]  cr_q, cr_next;
    logic [SW_W-1:0]  sw_q, sw_next;

    dpcmp_classify #(.DW(DW), .EXP_W(EXP_W)) u_cls_a (.op_i(opa_i), .cls_o(cls_a));
    dpcmp_classify #(.DW(DW), .EXP_W(EXP_W)) u_cls_b (.op_i(opb_i), .cls_o(cls_b));

    dpcmp_order #(.DW(DW)) u_order (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .a_zero_i (cls_a.is_zero),
        .b_zero_i (cls_b.is_zero),
        .lt_o     (lt),
        .gt_o     (gt),
        .eq_o     (eq)
    );

    always_comb begin
        unord    = cls_a.is_nan  || cls_b.is_nan;
        snan_any = cls_a.is_snan || cls_b.is_snan;
        qnan_any = cls_a.is_qnan || cls_b.is_qnan;
        code     = unord ? FW'(CODE_UNORD) : FW'({lt, gt, eq, 1'b0});
    end

    dpcmp_fieldwrite #(.NFIELD(NFIELD), .FW(FW)) u_steer (
        .cr_i   (cr_q),
        .idx_i  (bf_i),
        .code_i (code),
        .cr_o   (cr_next)
    );

    always_comb begin
        sw_next                  = sw_q;
        sw_next[SW_LT_BIT]       = code[3];
        sw_next[SW_GT_BIT]       = code[2];
        sw_next[SW_EQ_BIT]       = code[1];
        sw_next[SW_UN_BIT]       = code[0];
        sw_next[SW_SIGNAN_BIT]   = sw_q[SW_SIGNAN_BIT] | snan_any;
        sw_next[SW_INVCMP_BIT]   = sw_q[SW_INVCMP_BIT] | qnan_any | (snan_any & ~inv_en_i);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = valid_i ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = valid_i ? ST_COMMIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cr_q <= '0;
            sw_q <= '0;
        end else if (valid_i) begin
            cr_q <= cr_next;
            sw_q <= sw_next;
        end
    end

    assign cr_o    = cr_q;
    assign fpscr_o = sw_q;
    assign done_o  = (state_q == ST_COMMIT);

endmodule

// File: rtl/dp_ordcmp_checker.sv
module dp_ordcmp_checker #(
    parameter int CR_W = 32,
    parameter int SW_W = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            valid_i,
    input logic [CR_W-1:0] cr_o,
    input logic [SW_W-1:0] fpscr_o,
    input logic            done_o
);
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> done_o); // R2
    AST_DONE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> $past(valid_i)); // R2
    AST_CODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> ($countones(fpscr_o[15:12]) == 1)); // R3
    AST_SIGNAN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) !$fell(fpscr_o[24])); // R11
    AST_INVCMP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) !$fell(fpscr_o[19])); // R11
    AST_CR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> $stable(cr_o)); // R12
    AST_SW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> $stable(fpscr_o)); // R12
endmodule

bind dp_ordcmp_unit dp_ordcmp_checker #(.CR_W(NFIELD*FW), .SW_W(32)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .cr_o    (cr_o),
    .fpscr_o (fpscr_o),
    .done_o  (done_o)
);

// File: tb/dp_ordcmp_unit_tb.sv
module dp_ordcmp_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic [2:0]  bf = '0;
    logic        inv_en = 1'b0;
    logic [31:0] cr, fs;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit reported = 0;

    logic [31:0] q_cr[$];
    logic [31:0] q_fs[$];
    string       q_tag[$];
    logic [31:0] mdl_cr = '0, mdl_fs = '0;   // model after last issued op
    logic [31:0] cur_cr = '0, cur_fs = '0;   // model after last observed commit

    localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] BIGV   = 64'h7E37_E43C_8800_759C;
    localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;

    dp_ordcmp_unit u_dut (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opa_i(opa), .opb_i(opb),
        .bf_i(bf), .inv_en_i(inv_en), .cr_o(cr), .fpscr_o(fs), .done_o(done)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic bit is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [63:0] v);
        return is_nan(v) && !v[51];
    endfunction

    function automatic logic [3:0] ref_code(input logic [63:0] a, input logic [63:0] b);
        real ra, rb;
        if (is_nan(a) || is_nan(b)) return 4'b0001;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (ra < rb) return 4'b1000;
        if (ra > rb) return 4'b0100;
        return 4'b0010;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Driver: issue a compare, push the expected registers
    task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [2:0] f,
                         input logic ve, input string tag);
        logic [3:0] c;
        @(negedge clk);
        opa = a; opb = b; bf = f; inv_en = ve; valid = 1'b1;
        c = ref_code(a, b);
        mdl_cr[31-4*f -: 4] = c;
        mdl_fs[15:12] = c;
        if (is_snan(a) || is_snan(b)) mdl_fs[24] = 1'b1;
        if ((is_nan(a) && !is_snan(a)) || (is_nan(b) && !is_snan(b))
            || ((is_snan(a) || is_snan(b)) && !ve)) mdl_fs[19] = 1'b1;
        q_cr.push_back(mdl_cr);
        q_fs.push_back(mdl_fs);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid = 1'b0;
            opa = {$urandom, $urandom}; opb = QNAN; bf = 3'(i); inv_en = ~inv_en;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        valid = 1'b0;
        rst_n = 1'b0;
        q_cr.delete(); q_fs.delete(); q_tag.delete();
        mdl_cr = '0; mdl_fs = '0; cur_cr = '0; cur_fs = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cr reset", cr, 32'h0);
        chk("R1 fpscr reset", fs, 32'h0);
        chk("R1 done reset", {31'h0, done}, 32'h0);
    endtask

    // Monitor: compare commits against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                if (done) begin
                    if (q_cr.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R2 done without request act=1 exp=0");
                    end else begin
                        string t;
                        t = q_tag.pop_front();
                        cur_cr = q_cr.pop_front();
                        cur_fs = q_fs.pop_front();
                        chk({t, " cr"}, cr, cur_cr);
                        chk({t, " fpscr"}, fs, cur_fs);
                    end
                end else begin
                    chk("R12 cr hold", cr, cur_cr);
                    chk("R12 fpscr hold", fs, cur_fs);
                end
            end
        end
    end

    initial begin
        do_reset();
        issue(64'h400C_0000_0000_0000, 64'hC053_4000_0000_0000, 3'd6, 1'b0, "R3 R9 example gt field6");
        idle(2);
        issue(P_ONE, P_TWO, 3'd0, 1'b0, "R9 R10 lt field0 neighbours kept");
        issue(P_TWO, P_TWO, 3'd7, 1'b0, "R3 R9 eq field7 back-to-back");
        issue(N_ONE, N_TWO, 3'd2, 1'b1, "R3 negatives gt");
        issue(P_ZERO, N_ZERO, 3'd3, 1'b0, "R4 +0 vs -0");
        issue(N_ZERO, P_ZERO, 3'd4, 1'b0, "R4 -0 vs +0");
        issue(N_INF, P_INF, 3'd5, 1'b0, "R4 -inf vs +inf");
        issue(P_INF, BIGV, 3'd1, 1'b0, "R4 +inf vs big");
        idle(3);
        issue(SNAN, P_ONE, 3'd1, 1'b1, "R5 R6 R7 snan trap enabled");
        idle(1);
        issue(P_ONE, N_ONE, 3'd1, 1'b1, "R10 R11 ordered after snan");
        idle(2);
        do_reset();
        issue(P_ONE, QNAN, 3'd2, 1'b1, "R5 R8 qnan trap enabled");
        issue(N_TWO, N_ONE, 3'd2, 1'b0, "R10 R11 lt after qnan");
        idle(2);
        do_reset();
        issue(P_TWO, SNAN, 3'd7, 1'b0, "R6 R7 snan trap disabled");
        issue(QNAN, SNAN, 3'd0, 1'b1, "R5 R6 R8 both nan");
        idle(3);
        chk("R2 scoreboard drained", 32'(q_cr.size()), 32'h0);
        finished = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R2 watchdog act=running exp=finished");
            report();
        end
    end

endmodule